// File: doc/BRIEF.md
# Keyed configuration lock controller

This block protects a bank of configuration registers from stray writes. It watches byte writes to a control register. The protection flag in bit 6 of that byte may change only when a write follows a fixed two-byte key directly. While the flag is set, the block withdraws its write-permit output, so any write to the protected bank is accepted on the bus but changes nothing.

A one-way input, normally tied high, turns the flag into a fuse. Once the flag is set it cannot be cleared again until reset, and only the ability to set it remains.

The block also keeps its own shadow copy of every protected register. The shadow is updated only by permitted writes. The block compares the shadow with the live contents of the bank, which it receives as an input, on every cycle. If the live contents change without a permitted write, for example through corruption, the block raises a sticky reset request.

Top module: `cfglock_ctrl`

## Requirements
- R1: After reset, `lock_o` is 0, `wr_permit_o` is 1 and `mismatch_o` is 0.
- R2: Three control writes on consecutive cycles, with data 0x46, then 0x57, then any byte V, load bit 6 of V into `lock_o`. The new value is visible after the clock edge that takes V.
- R3: A control write not preceded by the key, whatever the value of its bit 6, leaves `lock_o` unchanged. The key bytes themselves never alter `lock_o`.
- R4: If the first key write carries a byte other than 0x46, or the second carries a byte other than 0x57, the sequence is abandoned, and the write that follows does not change `lock_o`.
- R5: A cycle without a control write, either between the two key bytes or between the second key byte and the update, abandons the sequence. A later write to bit 6 is then ignored.
- R6: While `lock_o` is 1, `wr_permit_o` is 0 and protected-bank writes leave the shadow copy unchanged. While `lock_o` is 0, `wr_permit_o` is 1.
- R7: `lock_o` holds its value in every cycle that carries no control write.
- R8: With `one_way_i` high, a keyed update whose bit 6 is 0 leaves a set `lock_o` at 1. With `one_way_i` low, the same update clears it.
- R9: Each permitted write (`cfg_wr_i` with `wr_permit_o` high) stores `cfg_wdata_i` into shadow entry `cfg_idx_i`. A bank that follows the same writes therefore never raises `mismatch_o`.
- R10: If any live entry differs from its shadow at a clock edge, `mismatch_o` rises after that edge and stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| one_way_i | input | 1 | When high, the lock cannot be cleared once set |
| ctl_wr_i | input | 1 | Byte write strobe to the control register low byte |
| ctl_wdata_i | input | CTL_W | Byte written to the control register |
| cfg_wr_i | input | 1 | Write strobe to the protected bank |
| cfg_idx_i | input | $clog2(NREG) | Protected entry being written |
| cfg_wdata_i | input | DW | Data written to the protected entry |
| live_i | input | NREG*DW | Live contents of the protected bank, entry i at bits [i*DW +: DW] |
| wr_permit_o | output | 1 | High when the protected bank may accept writes |
| lock_o | output | 1 | Current lock flag |
| mismatch_o | output | 1 | Sticky configuration-mismatch reset request |

## Verification
The assertions take for granted three things about the inputs. The live bank applies exactly the writes that arrive while `wr_permit_o` is high, on the same edge as the shadow. Control-register writes are single bytes with defined data. `one_way_i` stays constant while a keyed update is in flight. The stimulus keeps to these rules: a behavioural bank in the bench applies permitted writes and nothing else, except for single deliberate bit flips, which exist only to test mismatch detection. All inputs are driven to known values from before reset onward, and `one_way_i` changes only in idle cycles. Sweeps over all 256 values of each key byte exercise the sequence detector around its single accepted pattern.

// File: rtl/cfglock_pkg.sv
package cfglock_pkg;
   typedef enum logic [1:0] {
      KS_IDLE  = 2'd0,
      KS_HALF  = 2'd1,
      KS_ARMED = 2'd2
   } keyseq_e;
endpackage

// File: rtl/cfglock_keyseq.sv
module cfglock_keyseq
   import cfglock_pkg::*;
#(
   parameter int            CTL_W    = 8,
   parameter logic [CTL_W-1:0] KEY_A = 8'h46,
   parameter logic [CTL_W-1:0] KEY_B = 8'h57,
   parameter int            LOCK_POS = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ctl_wr_i,
   input  logic [CTL_W-1:0] ctl_wdata_i,
   output logic             commit_o,
   output logic             commit_val_o
);
   keyseq_e state_q, state_d;

   always_comb begin
      state_d = KS_IDLE;
      if (ctl_wr_i) begin
         unique case (state_q)
            KS_IDLE:  state_d = (ctl_wdata_i == KEY_A) ? KS_HALF  : KS_IDLE;
            KS_HALF:  state_d = (ctl_wdata_i == KEY_B) ? KS_ARMED : KS_IDLE;
            default:  state_d = KS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) state_q <= KS_IDLE;
      else         state_q <= state_d;
   end

   assign commit_o     = ctl_wr_i && (state_q == KS_ARMED);
   assign commit_val_o = ctl_wdata_i[LOCK_POS];
endmodule

// File: rtl/cfglock_lockreg.sv
module cfglock_lockreg (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic one_way_i,
   input  logic commit_i,
   input  logic commit_val_i,
   output logic lock_o
);
   logic lock_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         lock_q <= 1'b0;
      end else if (commit_i) begin
         if (commit_val_i)                lock_q <= 1'b1;
         else if (!(one_way_i && lock_q)) lock_q <= 1'b0;
      end
   end

   assign lock_o = lock_q;
endmodule

// File: rtl/cfglock_shadow.sv
module cfglock_shadow #(
   parameter int NREG = 4,
   parameter int DW   = 8,
   localparam int IW  = $clog2(NREG),
   localparam int FW  = NREG * DW
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          wr_en_i,
   input  logic [IW-1:0] idx_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [FW-1:0] live_i,
   output logic [FW-1:0] shadow_o,
   output logic          mismatch_o
);
   logic [NREG-1:0] diff;
   logic            mism_q;

   for (genvar i = 0; i < NREG; i++) begin : g_entry
      logic [DW-1:0] ent_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni)                             ent_q <= '0;
         else if (wr_en_i && (idx_i == IW'(i)))   ent_q <= wdata_i;
      end
      assign shadow_o[i*DW +: DW] = ent_q;
      assign diff[i] = (live_i[i*DW +: DW] != ent_q);
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     mism_q <= 1'b0;
      else if (|diff)  mism_q <= 1'b1;
   end

   assign mismatch_o = mism_q;
endmodule

// File: rtl/cfglock_ctrl.sv
module cfglock_ctrl #(
   parameter int               NREG     = 4,
   parameter int               DW       = 8,
   parameter int               CTL_W    = 8,
   parameter logic [CTL_W-1:0] KEY_A    = 8'h46,
   parameter logic [CTL_W-1:0] KEY_B    = 8'h57,
   parameter int               LOCK_POS = 6,
   localparam int              IW       = $clog2(NREG),
   localparam int              FW       = NREG * DW
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             one_way_i,
   input  logic             ctl_wr_i,
   input  logic [CTL_W-1:0] ctl_wdata_i,
   input  logic             cfg_wr_i,
   input  logic [IW-1:0]    cfg_idx_i,
   input  logic [DW-1:0]    cfg_wdata_i,
   input  logic [FW-1:0]    live_i,
   output logic             wr_permit_o,
   output logic             lock_o,
   output logic             mismatch_o
);
   if (NREG < 2) begin : g_bad_nreg
      $error("cfglock_ctrl: NREG must be at least 2");
   end
   if (LOCK_POS >= CTL_W) begin : g_bad_pos
      $error("cfglock_ctrl: LOCK_POS outside control byte");
   end
   if (KEY_A == KEY_B) begin : g_bad_key
      $error("cfglock_ctrl: key bytes must differ");
   end

   logic          commit, commit_val, lock;
   logic [FW-1:0] shadow_flat;

   cfglock_keyseq #(
      .CTL_W(CTL_W), .KEY_A(KEY_A), .KEY_B(KEY_B), .LOCK_POS(LOCK_POS)
   ) u_keyseq (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i),
      .commit_o(commit), .commit_val_o(commit_val)
   );

   cfglock_lockreg u_lockreg (
      .clk_i(clk_i), .rst_ni(rst_ni), .one_way_i(one_way_i),
      .commit_i(commit), .commit_val_i(commit_val), .lock_o(lock)
   );

   cfglock_shadow #(.NREG(NREG), .DW(DW)) u_shadow (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_en_i(cfg_wr_i && !lock),
      .idx_i(cfg_idx_i), .wdata_i(cfg_wdata_i), .live_i(live_i),
      .shadow_o(shadow_flat), .mismatch_o(mismatch_o)
   );

   assign lock_o      = lock;
   assign wr_permit_o = !lock;
endmodule

// File: rtl/cfglock_ctrl_chk.sv
module cfglock_ctrl_chk #(
   parameter int               NREG  = 4,
   parameter int               DW    = 8,
   parameter int               CTL_W = 8,
   parameter logic [CTL_W-1:0] KEY_A = 8'h46,
   parameter logic [CTL_W-1:0] KEY_B = 8'h57
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               one_way_i,
   input logic               ctl_wr_i,
   input logic [CTL_W-1:0]   ctl_wdata_i,
   input logic               cfg_wr_i,
   input logic               wr_permit_o,
   input logic               lock_o,
   input logic               mismatch_o,
   input logic [NREG*DW-1:0] shadow_flat
);
   logic [1:0] since_rst;
   always_ff @(posedge clk_i) begin
      if (!rst_ni)               since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R7: no control write, no lock change
   a_r7_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctl_wr_i |=> $stable(lock_o));

   // R2/R3: a write changes the lock only when the key preceded it
   a_r3_key_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_wr_i && since_rst >= 2'd2 &&
       !($past(ctl_wr_i, 2) && $past(ctl_wdata_i, 2) == KEY_A &&
         $past(ctl_wr_i) && $past(ctl_wdata_i) == KEY_B))
      |=> $stable(lock_o));

   // R8: one-way fuse keeps a set lock
   a_r8_one_way: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (one_way_i && lock_o) |=> lock_o);

   // R6: blocked writes leave the shadow untouched
   a_r6_shadow_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_wr_i && !wr_permit_o) |=> $stable(shadow_flat));

   // R10: mismatch request is sticky
   a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mismatch_o |=> mismatch_o);
endmodule

bind cfglock_ctrl cfglock_ctrl_chk #(
   .NREG(NREG), .DW(DW), .CTL_W(CTL_W), .KEY_A(KEY_A), .KEY_B(KEY_B)
) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .one_way_i(one_way_i),
   .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i), .cfg_wr_i(cfg_wr_i),
   .wr_permit_o(wr_permit_o), .lock_o(lock_o), .mismatch_o(mismatch_o),
   .shadow_flat(shadow_flat)
);

// File: tb/test_cfglock_ctrl.sv
module test_cfglock_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NREG = 4;
   localparam int DW   = 8;
   localparam int IW   = $clog2(NREG);
   localparam logic [7:0] KA = 8'h46;
   localparam logic [7:0] KB = 8'h57;

   logic clk_i = 1'b0;
   logic rst_ni = 1'b0;
   logic one_way_i = 1'b1;
   logic ctl_wr_i = 1'b0;
   logic [7:0] ctl_wdata_i = '0;
   logic cfg_wr_i = 1'b0;
   logic [IW-1:0] cfg_idx_i = '0;
   logic [DW-1:0] cfg_wdata_i = '0;
   logic [NREG*DW-1:0] live = '0;
   logic inj = 1'b0;
   logic [NREG*DW-1:0] inj_mask = '0;
   logic wr_permit_o, lock_o, mismatch_o;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   cfglock_ctrl #(.NREG(NREG), .DW(DW)) i_cfglock_ctrl (
      .clk_i(clk_i), .rst_ni(rst_ni), .one_way_i(one_way_i),
      .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i),
      .cfg_wr_i(cfg_wr_i), .cfg_idx_i(cfg_idx_i), .cfg_wdata_i(cfg_wdata_i),
      .live_i(live), .wr_permit_o(wr_permit_o), .lock_o(lock_o),
      .mismatch_o(mismatch_o)
   );

   // behavioural protected bank: applies permitted writes, plus injected flips
   always_ff @(posedge clk_i) begin
      if (!rst_ni) live <= '0;
      else begin
         if (cfg_wr_i && wr_permit_o) live[cfg_idx_i*DW +: DW] <= cfg_wdata_i;
         if (inj) live <= live ^ inj_mask;
      end
   end

   always @(posedge clk_i) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(string req, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk_i);
      ctl_wr_i = 0; cfg_wr_i = 0; inj = 0;
   endtask

   task automatic ctl(logic [7:0] b);
      @(negedge clk_i);
      ctl_wr_i = 1; ctl_wdata_i = b; cfg_wr_i = 0; inj = 0;
   endtask

   task automatic cw(int idx, logic [DW-1:0] d);
      @(negedge clk_i);
      ctl_wr_i = 0; cfg_wr_i = 1; cfg_idx_i = IW'(idx); cfg_wdata_i = d; inj = 0;
   endtask

   task automatic keyed(logic [7:0] v);
      ctl(KA); ctl(KB); ctl(v); idle();
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      rst_ni = 1;
      idle();
      // R1
      chk("R1 lock", lock_o, 1'b0);
      chk("R1 permit", wr_permit_o, 1'b1);
      chk("R1 mismatch", mismatch_o, 1'b0);

      // R9: permitted writes mirrored, no mismatch
      for (int i = 0; i < NREG; i++) cw(i, DW'(8'h11 * (i + 1)));
      for (int i = 0; i < NREG; i++) cw(NREG - 1 - i, DW'(8'hA5 ^ (i * 37)));
      idle(); idle();
      chk("R9 mismatch after permitted writes", mismatch_o, 1'b0);

      // R3: unkeyed writes with bit 6 set, key bytes alone
      ctl(8'h40); ctl(8'hFF); ctl(KA); idle();
      chk("R3 unkeyed write", lock_o, 1'b0);
      ctl(KA); ctl(KB); idle(); idle();
      chk("R3 key bytes alone", lock_o, 1'b0);

      // R4 sweep of the second key byte, R2 set/clear
      one_way_i = 0;
      for (int b = 0; b < 256; b++) begin
         ctl(KA); ctl(8'(b)); ctl(8'h40); idle();
         chk($sformatf("R4 second byte %02h", b), lock_o, (b == KB));
         if (lock_o) begin
            keyed(8'hBF);
            chk("R2 clear with bit6=0", lock_o, 1'b0);
         end
      end
      // R4 sweep of the first key byte
      for (int a = 0; a < 256; a++) begin
         ctl(8'(a)); ctl(KB); ctl(8'h40); idle();
         chk($sformatf("R4 first byte %02h", a), lock_o, (a == KA));
         if (lock_o) begin
            keyed(8'h00);
            chk("R2 clear", lock_o, 1'b0);
         end
      end

      // R5: gaps abort
      ctl(KA); idle(); ctl(KB); ctl(8'h40); idle();
      chk("R5 gap between key bytes", lock_o, 1'b0);
      ctl(KA); ctl(KB); idle(); ctl(8'h40); idle();
      chk("R5 gap before update", lock_o, 1'b0);

      // R2 set with other bits present
      keyed(8'h7F);
      chk("R2 set", lock_o, 1'b1);
      // R6: locked bank
      chk("R6 permit low", wr_permit_o, 1'b0);
      for (int i = 0; i < NREG; i++) cw(i, DW'(8'h3C + i));
      idle(); idle();
      chk("R6 permit still low", wr_permit_o, 1'b0);
      chk("R6 shadow unchanged", mismatch_o, 1'b0);
      // R7: hold through idle and unkeyed writes
      repeat (5) idle();
      ctl(8'h00); ctl(8'h00); idle();
      chk("R7 lock holds", lock_o, 1'b1);

      // R8: one-way fuse
      one_way_i = 1;
      idle();
      keyed(8'h00);
      chk("R8 one-way keeps lock", lock_o, 1'b1);
      keyed(8'h40);
      chk("R8 one-way still set", lock_o, 1'b1);
      one_way_i = 0;
      idle();
      keyed(8'h00);
      chk("R8 cleared without one-way", lock_o, 1'b0);
      chk("R6 permit high again", wr_permit_o, 1'b1);
      cw(2, 8'h99); idle(); idle();
      chk("R9 write after unlock", mismatch_o, 1'b0);

      // R10: corruption detection, sticky
      @(negedge clk_i);
      inj_mask = '0; inj_mask[DW + 3] = 1'b1; inj = 1;
      idle();
      chk("R10 not yet", mismatch_o, 1'b0);
      idle();
      chk("R10 raised", mismatch_o, 1'b1);
      cw(1, live[DW +: DW] ^ 8'h08);
      repeat (4) idle();
      chk("R10 sticky", mismatch_o, 1'b1);
      rst_ni = 0;
      idle(); idle();
      rst_ni = 1;
      idle();
      chk("R10 cleared by reset", mismatch_o, 1'b0);
      chk("R1 lock after reset", lock_o, 1'b0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule